// File: doc/BRIEF.md
# Exception Dispatch Unit

This block takes a raised synchronous exception or a debug request and works out which handler vector the core must enter. It also updates the architectural exception-state registers. A request carries the faulting program counter, a cause code and, for address faults, the faulting virtual address. The block reads the current processor status word, returns the new status word together with the vector select, and keeps the saved-PC, saved-status, cause and fault-address registers itself.

The status word layout is `[3:0]` interrupt level, bit 4 exception-mode flag, bit 5 user-mode flag. Any bits above these pass through unchanged. `acc_o` is the accept strobe. While it is high, `vec_o` and `ps_o` are valid, and every register update commits on that clock edge. A debug request that is gated off is not accepted. It leaves all state as it was.

The vector codes are 0 none, 1 kernel, 2 user, 3 double, 4 debug. Two parameters select the variant. `DBG_LEVEL` (2 to 6) sets the debug level. `HAS_DEPC` selects whether a separate double-exception PC register exists.

Top module: `exc_dispatch`

## Requirements
- R1: After reset every saved register output is zero. With no request pending, `acc_o` is 0, `vec_o` is 0 (none) and `ps_o` equals `ps_i`.
- R2: A general request taken while `ps_i[4]` is 0 is accepted. The next value of the level-1 saved PC is `pc_i`. `vec_o` is 2 (user) when `ps_i[5]` is 1, otherwise 1 (kernel).
- R3: A general request taken while `ps_i[4]` is 1 gives `vec_o` 3 (double). The PC goes to `depc_o` when `HAS_DEPC` is 1, and the level-1 saved PC is then unchanged. With `HAS_DEPC` 0 the PC goes to the level-1 saved PC and `depc_o` stays 0.
- R4: Every accepted general request loads `cause_i` into `cause_o`. `ps_o` is then `ps_i` with bit 4 set and all other bits unchanged.
- R5: `vaddr_o` takes `vaddr_i` on an accepted general request only when `addr_vld_i` is 1. Otherwise it holds its value.
- R6: A debug request with no general request present is accepted only when `ps_i[3:0]` is strictly less than `DBG_LEVEL`. If it is not accepted, `acc_o` is 0, `vec_o` is 0, `ps_o` equals `ps_i`, and no register changes.
- R7: An accepted debug request gives `vec_o` 4. It loads `dcause_i` into `dcause_o`, `pc_i` into the saved PC of level `DBG_LEVEL`, and `ps_i` into the saved status of level `DBG_LEVEL`. `ps_o` is `ps_i` with `[3:0]` = `DBG_LEVEL` and bit 4 set. `cause_o` is unchanged.
- R8: When a general and a debug request arrive in the same cycle, only the general request is acted on. `dcause_o` and all saved-status registers stay unchanged.
- R9: Saved-PC levels and saved-status levels that the accepted request does not target keep their values. Registers change only on an edge where `acc_o` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_req_i | input | 1 | General exception raised |
| dbg_req_i | input | 1 | Debug exception raised |
| addr_vld_i | input | 1 | Request carries a faulting address |
| pc_i | input | PC_W | Faulting program counter |
| cause_i | input | CAUSE_W | General cause code |
| dcause_i | input | CAUSE_W | Debug cause code |
| vaddr_i | input | PC_W | Faulting virtual address |
| ps_i | input | PS_W | Current status word |
| acc_o | output | 1 | Request accepted; state commits at this edge |
| vec_o | output | 3 | Vector select (0 none, 1 kernel, 2 user, 3 double, 4 debug) |
| ps_o | output | PS_W | New status word |
| epc_o | output | NLEV*PC_W | Saved PC, levels 1..6, level L at slice L-1 |
| eps_o | output | (NLEV-1)*PS_W | Saved status, levels 2..6, level L at slice L-2 |
| depc_o | output | PC_W | Double-exception saved PC |
| cause_o | output | CAUSE_W | General cause register |
| dcause_o | output | CAUSE_W | Debug cause register |
| vaddr_o | output | PC_W | Fault address register |

## Verification
The bench sweeps every 8-bit status word against each request kind. It does this on two configurations: debug level 4 with a double-exception register, and debug level 2 without one. This covers the interrupt level equal to the debug level, where a design using "less or equal" would wrongly take the debug request, and the level just above it. Double exceptions are checked on both configurations. A design that ignores the configured-register choice would overwrite the level-1 PC, or leave it stale, and every saved register is compared after each step. Simultaneous requests catch a design that lets debug win or updates both paths. Requests without an address catch a fault-address register that is overwritten when it should hold.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [2:0] {
        VEC_NONE   = 3'd0,
        VEC_KERNEL = 3'd1,
        VEC_USER   = 3'd2,
        VEC_DOUBLE = 3'd3,
        VEC_DEBUG  = 3'd4
    } vec_e;

    localparam int IL_LSB  = 0;
    localparam int IL_W    = 4;
    localparam int EXCM_BIT = 4;
    localparam int UM_BIT   = 5;
    localparam int NLEV     = 6;
endpackage

// File: rtl/exc_route.sv
module exc_route
    import exc_pkg::*;
#(
    parameter int PS_W     = 8,
    parameter bit HAS_DEPC = 1'b1
) (
    input  logic [PS_W-1:0] ps_i,
    output logic [2:0]      vec_o,
    output logic            to_depc_o,
    output logic [PS_W-1:0] ps_o
);
    logic in_exc;
    assign in_exc = ps_i[EXCM_BIT];

    always_comb begin
        if (in_exc)              vec_o = VEC_DOUBLE;
        else if (ps_i[UM_BIT])   vec_o = VEC_USER;
        else                     vec_o = VEC_KERNEL;
        ps_o           = ps_i;
        ps_o[EXCM_BIT] = 1'b1;
    end

    generate
        if (HAS_DEPC) begin : g_depc
            assign to_depc_o = in_exc;
        end else begin : g_nodepc
            assign to_depc_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/exc_dbg_gate.sv
module exc_dbg_gate
    import exc_pkg::*;
#(
    parameter int PS_W      = 8,
    parameter int DBG_LEVEL = 4
) (
    input  logic            dbg_req_i,
    input  logic            gen_req_i,
    input  logic [PS_W-1:0] ps_i,
    output logic            take_o,
    output logic [PS_W-1:0] ps_o
);
    localparam logic [IL_W-1:0] DL = IL_W'(DBG_LEVEL);

    logic lvl_ok;
    assign lvl_ok = ps_i[IL_LSB +: IL_W] < DL;
    assign take_o = dbg_req_i && !gen_req_i && lvl_ok;

    always_comb begin
        ps_o                  = ps_i;
        ps_o[IL_LSB +: IL_W]  = DL;
        ps_o[EXCM_BIT]        = 1'b1;
    end
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
    import exc_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int CAUSE_W   = 6,
    parameter int PS_W      = 8,
    parameter int DBG_LEVEL = 4,
    parameter bit HAS_DEPC  = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       gen_req_i,
    input  logic                       dbg_req_i,
    input  logic                       addr_vld_i,
    input  logic [PC_W-1:0]            pc_i,
    input  logic [CAUSE_W-1:0]         cause_i,
    input  logic [CAUSE_W-1:0]         dcause_i,
    input  logic [PC_W-1:0]            vaddr_i,
    input  logic [PS_W-1:0]            ps_i,
    output logic                       acc_o,
    output logic [2:0]                 vec_o,
    output logic [PS_W-1:0]            ps_o,
    output logic [NLEV*PC_W-1:0]       epc_o,
    output logic [(NLEV-1)*PS_W-1:0]   eps_o,
    output logic [PC_W-1:0]            depc_o,
    output logic [CAUSE_W-1:0]         cause_o,
    output logic [CAUSE_W-1:0]         dcause_o,
    output logic [PC_W-1:0]            vaddr_o
);
    localparam int PC_SLOT = DBG_LEVEL - 1;
    localparam int PS_SLOT = DBG_LEVEL - 2;

    typedef struct packed {
        logic [NLEV-1:0][PC_W-1:0]  epc;
        logic [NLEV-2:0][PS_W-1:0]  eps;
        logic [PC_W-1:0]            depc;
        logic [PC_W-1:0]            vaddr;
        logic [CAUSE_W-1:0]         cause;
        logic [CAUSE_W-1:0]         dcause;
    } state_t;

    state_t st_d, st_q;

    logic [2:0]      gen_vec;
    logic            gen_to_depc;
    logic [PS_W-1:0] gen_ps, dbg_ps;
    logic            dbg_take;

    exc_route #(.PS_W(PS_W), .HAS_DEPC(HAS_DEPC)) u_route (
        .ps_i      (ps_i),
        .vec_o     (gen_vec),
        .to_depc_o (gen_to_depc),
        .ps_o      (gen_ps)
    );

    exc_dbg_gate #(.PS_W(PS_W), .DBG_LEVEL(DBG_LEVEL)) u_dbg (
        .dbg_req_i (dbg_req_i),
        .gen_req_i (gen_req_i),
        .ps_i      (ps_i),
        .take_o    (dbg_take),
        .ps_o      (dbg_ps)
    );

    always_comb begin
        st_d  = st_q;
        acc_o = 1'b0;
        vec_o = VEC_NONE;
        ps_o  = ps_i;
        if (gen_req_i) begin
            acc_o = 1'b1;
            vec_o = gen_vec;
            ps_o  = gen_ps;
            if (gen_to_depc) st_d.depc   = pc_i;
            else             st_d.epc[0] = pc_i;
            st_d.cause = cause_i;
            if (addr_vld_i) st_d.vaddr = vaddr_i;
        end else if (dbg_take) begin
            acc_o = 1'b1;
            vec_o = VEC_DEBUG;
            ps_o  = dbg_ps;
            st_d.dcause       = dcause_i;
            st_d.epc[PC_SLOT] = pc_i;
            st_d.eps[PS_SLOT] = ps_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign epc_o    = st_q.epc;
    assign eps_o    = st_q.eps;
    assign depc_o   = st_q.depc;
    assign vaddr_o  = st_q.vaddr;
    assign cause_o  = st_q.cause;
    assign dcause_o = st_q.dcause;

    // R4
    cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_req_i |=> (cause_o == $past(cause_i)));

    // R4
    excm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> ps_o[EXCM_BIT]);

    // R5
    vaddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req_i && !addr_vld_i) |=> $stable(vaddr_o));

    // R7
    dbg_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o && vec_o == VEC_DEBUG) |=>
            (epc_o[PC_SLOT*PC_W +: PC_W] == $past(pc_i)) &&
            (eps_o[PS_SLOT*PS_W +: PS_W] == $past(ps_i)));

    // R8
    gen_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req_i && dbg_req_i) |=> ($stable(dcause_o) && $stable(eps_o)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_o |=> ($stable(epc_o) && $stable(cause_o) && $stable(depc_o)));

    // R3
    double_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req_i && ps_i[EXCM_BIT]) |-> (vec_o == VEC_DOUBLE));
endmodule

// File: tb/test_exc_dispatch.sv
module test_exc_dispatch;
    localparam int PC_W = 32;
    localparam int CW   = 6;
    localparam int PW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          gen_req, dbg_req, addr_vld;
    logic [PC_W-1:0] pc, vaddr;
    logic [CW-1:0] cause, dcause;
    logic [PW-1:0] ps;

    logic            acc [2];
    logic [2:0]      vec [2];
    logic [PW-1:0]   pso [2];
    logic [6*PC_W-1:0] epc [2];
    logic [5*PW-1:0] eps [2];
    logic [PC_W-1:0] depc [2], va [2];
    logic [CW-1:0]   ca [2], dca [2];

    exc_dispatch #(.DBG_LEVEL(4), .HAS_DEPC(1'b1)) i_exc_dispatch (
        .clk(clk), .rst_n(rst_n), .gen_req_i(gen_req), .dbg_req_i(dbg_req),
        .addr_vld_i(addr_vld), .pc_i(pc), .cause_i(cause), .dcause_i(dcause),
        .vaddr_i(vaddr), .ps_i(ps), .acc_o(acc[0]), .vec_o(vec[0]), .ps_o(pso[0]),
        .epc_o(epc[0]), .eps_o(eps[0]), .depc_o(depc[0]), .cause_o(ca[0]),
        .dcause_o(dca[0]), .vaddr_o(va[0]));

    exc_dispatch #(.DBG_LEVEL(2), .HAS_DEPC(1'b0)) i_exc_dispatch_nd (
        .clk(clk), .rst_n(rst_n), .gen_req_i(gen_req), .dbg_req_i(dbg_req),
        .addr_vld_i(addr_vld), .pc_i(pc), .cause_i(cause), .dcause_i(dcause),
        .vaddr_i(vaddr), .ps_i(ps), .acc_o(acc[1]), .vec_o(vec[1]), .ps_o(pso[1]),
        .epc_o(epc[1]), .eps_o(eps[1]), .depc_o(depc[1]), .cause_o(ca[1]),
        .dcause_o(dca[1]), .vaddr_o(va[1]));

    int total = 0;
    int bad   = 0;

    int cfg_dl [2] = '{4, 2};
    bit cfg_hd [2] = '{1'b1, 1'b0};

    logic [PC_W-1:0] m_epc [2][6];
    logic [PW-1:0]   m_eps [2][5];
    logic [PC_W-1:0] m_depc [2], m_va [2];
    logic [CW-1:0]   m_ca [2], m_dca [2];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_regs(input int c);
        for (int l = 0; l < 6; l++)
            chk($sformatf("R9 R2 R3 R7 epc cfg%0d lvl%0d", c, l+1),
                epc[c][l*PC_W +: PC_W], m_epc[c][l]);
        for (int l = 0; l < 5; l++)
            chk($sformatf("R9 R7 R8 eps cfg%0d lvl%0d", c, l+2),
                32'(eps[c][l*PW +: PW]), 32'(m_eps[c][l]));
        chk($sformatf("R3 depc cfg%0d", c), depc[c], m_depc[c]);
        chk($sformatf("R4 cause cfg%0d", c), 32'(ca[c]), 32'(m_ca[c]));
        chk($sformatf("R7 R8 dcause cfg%0d", c), 32'(dca[c]), 32'(m_dca[c]));
        chk($sformatf("R5 vaddr cfg%0d", c), va[c], m_va[c]);
    endtask

    task automatic step(input bit g, input bit d, input bit a, input logic [PW-1:0] p,
                        input logic [PC_W-1:0] pcv, input logic [CW-1:0] cv,
                        input logic [CW-1:0] dv, input logic [PC_W-1:0] vv);
        bit e_acc [2];
        logic [2:0] e_vec [2];
        logic [PW-1:0] e_ps [2];
        @(negedge clk);
        gen_req = g; dbg_req = d; addr_vld = a; ps = p;
        pc = pcv; cause = cv; dcause = dv; vaddr = vv;
        for (int c = 0; c < 2; c++) begin
            e_acc[c] = 1'b0; e_vec[c] = 3'd0; e_ps[c] = p;
            if (g) begin
                e_acc[c] = 1'b1;
                e_ps[c]  = p | 8'h10;
                if (p[4]) begin
                    e_vec[c] = 3'd3;
                    if (cfg_hd[c]) m_depc[c] = pcv; else m_epc[c][0] = pcv;
                end else begin
                    e_vec[c] = p[5] ? 3'd2 : 3'd1;
                    m_epc[c][0] = pcv;
                end
                m_ca[c] = cv;
                if (a) m_va[c] = vv;
            end else if (d && (int'(p[3:0]) < cfg_dl[c])) begin
                e_acc[c] = 1'b1;
                e_vec[c] = 3'd4;
                e_ps[c]  = (p & 8'hE0) | 8'h10 | 8'(cfg_dl[c]);
                m_dca[c] = dv;
                m_epc[c][cfg_dl[c]-1] = pcv;
                m_eps[c][cfg_dl[c]-2] = p;
            end
        end
        #1;
        for (int c = 0; c < 2; c++) begin
            chk($sformatf("R6 R2 acc cfg%0d", c), 32'(acc[c]), 32'(e_acc[c]));
            chk($sformatf("R2 R3 R7 vec cfg%0d", c), 32'(vec[c]), 32'(e_vec[c]));
            chk($sformatf("R4 R7 ps cfg%0d", c), 32'(pso[c]), 32'(e_ps[c]));
        end
        @(posedge clk);
        #1;
        for (int c = 0; c < 2; c++) chk_regs(c);
    endtask

    bit done = 1'b0;

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        gen_req = 0; dbg_req = 0; addr_vld = 0; ps = '0;
        pc = '0; cause = '0; dcause = '0; vaddr = '0;
        for (int c = 0; c < 2; c++) begin
            for (int l = 0; l < 6; l++) m_epc[c][l] = '0;
            for (int l = 0; l < 5; l++) m_eps[c][l] = '0;
            m_depc[c] = '0; m_va[c] = '0; m_ca[c] = '0; m_dca[c] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        for (int c = 0; c < 2; c++) begin
            chk("R1 reset acc", 32'(acc[c]), 32'd0);
            chk("R1 reset vec", 32'(vec[c]), 32'd0);
            chk("R1 reset ps passthrough", 32'(pso[c]), 32'(ps));
            chk_regs(c);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < 256; p++) begin
            for (int k = 0; k < 5; k++) begin
                logic [PC_W-1:0] pcv;
                pcv = 32'h4000_0000 ^ (32'(p) << 8) ^ (32'(k) * 32'h0101_0011);
                case (k)
                    0: step(1, 0, 0, 8'(p), pcv, 6'(p + k), 6'(p * 3 + 1), ~pcv);
                    1: step(1, 0, 1, 8'(p), pcv, 6'(p + 7), 6'(p * 5 + 2), ~pcv);
                    2: step(0, 1, 0, 8'(p), pcv, 6'(p + 9), 6'(p * 7 + 3), ~pcv);
                    3: step(1, 1, 1, 8'(p), pcv, 6'(p + 11), 6'(p + 33), pcv ^ 32'h55);
                    default: step(0, 0, 1, 8'(p), pcv, 6'(p), 6'(~p), pcv);
                endcase
            end
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule